// File: doc/BRIEF.md
# Transparent Video Memory Update Controller

This block lets a processor reach video memory that it cannot address directly. Software loads a 14-bit target address into two write-only byte registers. It then asks for one memory transfer by reading or writing a register index that has no storage behind it. The controller places that target address on the memory address bus that the display refresh logic normally owns. When the transfer is served it flags completion and advances the target address by one, so that successive transfers walk through memory.

Three mode inputs shape the behaviour. In shared mode the bus always carries the refresh address. In transparent mode the bus carries the target address in one of two ways. In interleaved timing it follows the phase clock level. In deferred timing a pending transfer is held back until horizontal or vertical blanking. An optional output gives a one-cycle high pulse on each served transfer. When that pulse is not enabled, the same output passes raster address bit 4 through.

Top module: `vid_upd_ctrl`

## Requirements
- R1: In the cycle after synchronous reset, `mem_addr` is 0x0000, `ma_aux` is 0 and `upd_ready` is 0. The target address is 0x0000 and no transfer is pending.
- R2: While `mode_transparent` is 0, `mem_addr` shows the `refresh_addr` sampled at the previous clock edge. A pending transfer is held but not served.
- R3: A write (`cpu_acc`=1, `cpu_wr`=1) to index 18 loads target bits 13:8 from `cpu_wdata[5:0]`. A write to index 19 loads bits 7:0 from `cpu_wdata[7:0]`. Reads of these indices leave the target address unchanged.
- R4: Any access, read or write, to index 31 creates a pending transfer. The transfer stays pending until it is served.
- R5: With `mode_transparent`=1 and `mode_interleave`=1, `mem_addr` shows the target address after an edge where `phase` was 1, and `refresh_addr` after an edge where `phase` was 0. A pending transfer is served at the first edge where `phase` is 1.
- R6: With `mode_transparent`=1 and `mode_interleave`=0, a pending transfer is served at the first edge where `hblank` or `vblank` is 1. `mem_addr` shows the target address for that one cycle only and shows `refresh_addr` at all other times.
- R7: With `mode_strobe`=1, `ma_aux` is 1 for exactly the cycle in which a served transfer is shown and 0 otherwise. With `mode_strobe`=0, `ma_aux` shows the `ras4` sampled at the previous edge.
- R8: Each served transfer increments the target address by one, and the address wraps from 0x3FFF to 0x0000.
- R9: Further requests that arrive while a transfer is already pending merge into it, and only one transfer is served.
- R10: `upd_ready` falls to 0 after a request and rises to 1 after the request is served. A request in the same cycle as a service leaves it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_acc | input | 1 | One-cycle register access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | 5 | Register index of the access |
| cpu_wdata | input | 8 | Write data |
| phase | input | 1 | Processor phase clock level |
| hblank | input | 1 | Horizontal blanking |
| vblank | input | 1 | Vertical blanking |
| refresh_addr | input | 14 | Display refresh address |
| ras4 | input | 1 | Raster address bit 4 |
| mode_transparent | input | 1 | 0 = shared, 1 = transparent access |
| mode_interleave | input | 1 | 1 = phase interleaved, 0 = deferred to blanking |
| mode_strobe | input | 1 | 1 = `ma_aux` is update pulse |
| mem_addr | output | 14 | Registered memory address bus |
| ma_aux | output | 1 | Update pulse or raster bit 4 |
| upd_ready | output | 1 | Update-ready status flag |

## Verification
The assertions assume that reset is held for at least one edge before any other activity. They also assume that the CPU strobe lasts exactly one cycle for each access. Beyond that, they take the mode, phase and blanking inputs as free-running levels that may change on any edge. The bench keeps the CPU strobe to single-cycle pulses. It changes every input only between clock edges, and it switches modes only while no transfer is being served. Each expected address then follows directly from the register writes and the count of transfers served.

// File: rtl/vid_upd_pkg.sv
package vid_upd_pkg;
  localparam int ADDR_W = 14;
  localparam int IDX_W  = 5;
  localparam int DATA_W = 8;
  localparam int HI_W   = ADDR_W - DATA_W;

  localparam logic [IDX_W-1:0] IDX_TGT_HI = IDX_W'(18);
  localparam logic [IDX_W-1:0] IDX_TGT_LO = IDX_W'(19);
  localparam logic [IDX_W-1:0] IDX_KICK   = IDX_W'(31);

  typedef struct packed {
    logic transparent;
    logic interleave;
    logic strobe;
  } upd_mode_t;
endpackage

// File: rtl/upd_target_reg.sv
module upd_target_reg #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_hi,
  input  logic              load_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              serve,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addr_n;

  always_comb begin
    addr_n = addr_q;
    if (load_hi || load_lo) begin
      if (load_hi) addr_n[ADDR_W-1:DATA_W] = wdata[HI_W-1:0];
      if (load_lo) addr_n[DATA_W-1:0]      = wdata;
    end else if (serve) begin
      addr_n = addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_n;
  end

  // R8
  addr_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (serve && !load_hi && !load_lo) |=> addr_q == ADDR_W'($past(addr_q) + ADDR_W'(1)));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!serve && !load_hi && !load_lo) |=> $stable(addr_q));
endmodule

// File: rtl/upd_req_track.sv
module upd_req_track (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  vid_upd_pkg::upd_mode_t mode,
  input  logic                  phase,
  input  logic                  hblank,
  input  logic                  vblank,
  output logic                  serve,
  output logic                  pend_q,
  output logic                  ready_q
);
  logic window;

  always_comb begin
    window = mode.interleave ? phase : (hblank || vblank);
    serve  = pend_q && mode.transparent && window;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      pend_q <= req || (pend_q && !serve);
      if (req)        ready_q <= 1'b0;
      else if (serve) ready_q <= 1'b1;
    end
  end

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !serve) |=> pend_q);

  // R10
  ready_set_chk: assert property (@(posedge clk) disable iff (rst)
    (serve && !req) |=> ready_q);

  // R10
  ready_clr_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> !ready_q);

  // R2
  shared_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !mode.transparent |-> !serve);
endmodule

// File: rtl/upd_bus_mux.sv
module upd_bus_mux #(
  parameter int ADDR_W = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  vid_upd_pkg::upd_mode_t mode,
  input  logic                  phase,
  input  logic                  serve,
  input  logic [ADDR_W-1:0]     refresh_addr,
  input  logic [ADDR_W-1:0]     target_addr,
  input  logic                  ras4,
  output logic [ADDR_W-1:0]     mem_addr_q,
  output logic                  aux_q
);
  logic show_target;

  always_comb begin
    show_target = mode.transparent && ((mode.interleave && phase) || serve);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr_q <= '0;
      aux_q      <= 1'b0;
    end else begin
      mem_addr_q <= show_target ? target_addr : refresh_addr;
      aux_q      <= mode.strobe ? serve : ras4;
    end
  end

  // R2
  shared_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !mode.transparent |=> mem_addr_q == $past(refresh_addr));

  // R7
  strobe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode.strobe && !serve) |=> !aux_q);
endmodule

// File: rtl/vid_upd_ctrl.sv
module vid_upd_ctrl
  import vid_upd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_acc,
  input  logic              cpu_wr,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              phase,
  input  logic              hblank,
  input  logic              vblank,
  input  logic [ADDR_W-1:0] refresh_addr,
  input  logic              ras4,
  input  logic              mode_transparent,
  input  logic              mode_interleave,
  input  logic              mode_strobe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ma_aux,
  output logic              upd_ready
);
  upd_mode_t         mode;
  logic              load_hi, load_lo, kick, serve, pend;
  logic [ADDR_W-1:0] target;

  always_comb begin
    mode.transparent = mode_transparent;
    mode.interleave  = mode_interleave;
    mode.strobe      = mode_strobe;
    load_hi = cpu_acc && cpu_wr && (cpu_idx == IDX_TGT_HI);
    load_lo = cpu_acc && cpu_wr && (cpu_idx == IDX_TGT_LO);
    kick    = cpu_acc && (cpu_idx == IDX_KICK);
  end

  upd_target_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tgt (
    .clk(clk), .rst(rst), .load_hi(load_hi), .load_lo(load_lo),
    .wdata(cpu_wdata), .serve(serve), .addr_q(target)
  );

  upd_req_track u_req (
    .clk(clk), .rst(rst), .req(kick), .mode(mode), .phase(phase),
    .hblank(hblank), .vblank(vblank), .serve(serve), .pend_q(pend),
    .ready_q(upd_ready)
  );

  upd_bus_mux #(.ADDR_W(ADDR_W)) u_mux (
    .clk(clk), .rst(rst), .mode(mode), .phase(phase), .serve(serve),
    .refresh_addr(refresh_addr), .target_addr(target), .ras4(ras4),
    .mem_addr_q(mem_addr), .aux_q(ma_aux)
  );

  // R9
  merge_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && kick && !serve) |=> pend);
endmodule

// File: tb/tb_vid_upd_ctrl.sv
module tb_vid_upd_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_acc, cpu_wr;
  logic [4:0]  cpu_idx;
  logic [7:0]  cpu_wdata;
  logic        phase, hblank, vblank, ras4;
  logic [13:0] refresh_addr;
  logic        mode_transparent, mode_interleave, mode_strobe;
  logic [13:0] mem_addr;
  logic        ma_aux, upd_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  vid_upd_ctrl dut (
    .clk(clk), .rst(rst), .cpu_acc(cpu_acc), .cpu_wr(cpu_wr),
    .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata), .phase(phase),
    .hblank(hblank), .vblank(vblank), .refresh_addr(refresh_addr),
    .ras4(ras4), .mode_transparent(mode_transparent),
    .mode_interleave(mode_interleave), .mode_strobe(mode_strobe),
    .mem_addr(mem_addr), .ma_aux(ma_aux), .upd_ready(upd_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic acc(input bit wr, input logic [4:0] idx, input logic [7:0] d);
    cpu_acc = 1'b1; cpu_wr = wr; cpu_idx = idx; cpu_wdata = d;
    cyc();
    cpu_acc = 1'b0; cpu_wr = 1'b0; cpu_idx = '0; cpu_wdata = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    refresh_addr = 14'h1111; ras4 = 1'b1;
    cyc(); cyc();
    check(mem_addr == 14'h0, "R1 mem_addr", mem_addr, 0);
    check(ma_aux == 1'b0, "R1 ma_aux", ma_aux, 0);
    check(upd_ready == 1'b0, "R1 upd_ready", upd_ready, 0);
    rst = 1'b0;
    ras4 = 1'b0;
  endtask

  task automatic t_shared();
    mode_transparent = 1'b0; mode_interleave = 1'b0; mode_strobe = 1'b0;
    hblank = 1'b1; refresh_addr = 14'h1234; ras4 = 1'b1;
    acc(1'b0, 5'd31, 8'h00);
    check(upd_ready == 1'b0, "R10 ready low after request", upd_ready, 0);
    cyc();
    check(mem_addr == 14'h1234, "R2 shared bus", mem_addr, 14'h1234);
    check(ma_aux == 1'b1, "R7 aux follows ras4", ma_aux, 1);
    check(upd_ready == 1'b0, "R2 not served in shared", upd_ready, 0);
    refresh_addr = 14'h0ABC; ras4 = 1'b0;
    cyc();
    check(mem_addr == 14'h0ABC, "R2 shared bus tracks", mem_addr, 14'h0ABC);
    check(ma_aux == 1'b0, "R7 aux follows ras4 low", ma_aux, 0);
    hblank = 1'b0;
  endtask

  task automatic t_interleave();
    acc(1'b1, 5'd18, 8'hEA);
    acc(1'b1, 5'd19, 8'h55);
    acc(1'b0, 5'd18, 8'h00);
    mode_transparent = 1'b1; mode_interleave = 1'b1;
    phase = 1'b0; refresh_addr = 14'h0101;
    cyc();
    check(mem_addr == 14'h0101, "R5 phase low refresh", mem_addr, 14'h0101);
    check(upd_ready == 1'b0, "R4 still pending", upd_ready, 0);
    phase = 1'b1;
    cyc();
    check(mem_addr == 14'h2A55, "R3/R5 loaded target on bus", mem_addr, 14'h2A55);
    check(upd_ready == 1'b1, "R10 ready after serve", upd_ready, 1);
    cyc();
    check(mem_addr == 14'h2A56, "R8 incremented once", mem_addr, 14'h2A56);
    phase = 1'b0;
    cyc();
    check(mem_addr == 14'h0101, "R5 back to refresh", mem_addr, 14'h0101);
  endtask

  task automatic t_deferred();
    mode_interleave = 1'b0; mode_strobe = 1'b1;
    hblank = 1'b0; vblank = 1'b0; refresh_addr = 14'h0202;
    acc(1'b1, 5'd31, 8'h00);
    check(upd_ready == 1'b0, "R10 cleared by request", upd_ready, 0);
    acc(1'b0, 5'd31, 8'h00);
    check(mem_addr == 14'h0202, "R6 no service outside blank", mem_addr, 14'h0202);
    check(ma_aux == 1'b0, "R7 no pulse outside service", ma_aux, 0);
    hblank = 1'b1;
    cyc();
    check(mem_addr == 14'h2A56, "R6 served in hblank", mem_addr, 14'h2A56);
    check(ma_aux == 1'b1, "R7 pulse on service", ma_aux, 1);
    check(upd_ready == 1'b1, "R10 ready set", upd_ready, 1);
    cyc();
    check(mem_addr == 14'h0202, "R9 merged to single service", mem_addr, 14'h0202);
    check(ma_aux == 1'b0, "R7 pulse one cycle", ma_aux, 0);
    hblank = 1'b0;
    acc(1'b1, 5'd31, 8'h00);
    vblank = 1'b1;
    cyc();
    check(mem_addr == 14'h2A57, "R6/R8 served in vblank", mem_addr, 14'h2A57);
    vblank = 1'b0;
    cyc();
  endtask

  task automatic t_wrap();
    acc(1'b1, 5'd18, 8'hFF);
    acc(1'b1, 5'd19, 8'hFF);
    acc(1'b1, 5'd31, 8'h00);
    hblank = 1'b1;
    cyc();
    check(mem_addr == 14'h3FFF, "R3 high bits masked", mem_addr, 14'h3FFF);
    hblank = 1'b0;
    acc(1'b0, 5'd31, 8'h00);
    mode_strobe = 1'b0; ras4 = 1'b1;
    hblank = 1'b1;
    cyc();
    check(mem_addr == 14'h0000, "R8 wrap to zero", mem_addr, 0);
    check(ma_aux == 1'b1, "R7 aux is ras4 when strobe off", ma_aux, 1);
    hblank = 1'b0;
    cyc();
  endtask

  initial begin
    rst = 1'b1; cpu_acc = 1'b0; cpu_wr = 1'b0; cpu_idx = '0; cpu_wdata = '0;
    phase = 1'b0; hblank = 1'b0; vblank = 1'b0; ras4 = 1'b0;
    refresh_addr = '0; mode_transparent = 1'b0; mode_interleave = 1'b0;
    mode_strobe = 1'b0;
    @(negedge clk);
    t_reset();
    t_shared();
    t_interleave();
    t_deferred();
    t_wrap();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule